// File: doc/BRIEF.md
# Watchdog Timer Peripheral

This block is a watchdog timer that software reaches through two 32-bit registers on a simple memory-mapped bus. A control word sets the timer running, reloads it, picks the action taken when it expires, and reports whether it has expired and whether the hardware is unavailable. A count word holds the timeout in ticks. A prescaler inside the block divides the clock into ticks. A 2-bit select picks one of four divider settings, and the longest default setting gives one tick per second at a 125 MHz clock.

To arm the timer, software writes the count, sets the run bit, and then writes the reload bit. After that it must write reload again before the live count runs out. When the count runs out, the block latches the fired flag, stops itself, and pulses either a system-reset request or a shutdown request for one clock. The fired flag is cleared only by power-on reset. It therefore survives the system reset that the watchdog requests, and software can read it afterwards to learn the cause of that reset.

The bus has no handshake. A write completes in the cycle where `bus_en` and `bus_we` are high, and read data is a combinational function of `bus_addr`. The block has no streaming interface, so no valid/ready back-pressure applies.

Top module: `wdt_periph`

## Requirements
- R1: After power-on reset, the control word (offset 0x0) reads 0, the count word (offset 0x4) reads 0, and both request outputs are low.
- R2: A write to offset 0x4 stores bits 15:0 as the programmed count. A read of offset 0x4 returns that count with bits 31:16 as zero.
- R3: Control bits 6:4 and 31:8 always read as zero, and writing ones to them changes nothing.
- R4: Writing 1 to control bit 7 (reload) loads the programmed count into the live counter. Bit 7 reads 1 in the cycle after that write and reads 0 from then on.
- R5: Control bit 0 is run. With run at 1, the tick divisor at D cycles and a reload of count N at clock edge E, the timer expires at edge E+N·D. At that edge control bit 1 (fired) becomes 1 and run becomes 0.
- R6: Control bit 2 selects the expiry action. A value of 0 pulses `rst_req` for exactly one cycle, and a value of 1 pulses `shdn_req` for exactly one cycle. The other request output stays low.
- R7: Clearing run stops the count without losing the live value and without any expiry. Setting run again at edge S with R ticks left expires at edge S+R·D.
- R8: A reload written before expiry restarts the full timeout, counted from the reload edge.
- R9: A programmed count of 0 behaves as 1 tick, so the timer expires D cycles after the reload.
- R10: Writing 1 to control bit 1 clears fired. Writing 0 to bit 1 leaves it unchanged.
- R11: `rst_n` resets every register except fired. Only `por_n` clears fired.
- R12: Control bit 3 reads `hw_disable`. While it is 1, run and reload cannot be set, a running timer stops, and no request is produced.
- R13: `tick_sel` values 0, 1, 2 and 3 select divisors DIV_SEL0, DIV_SEL1, DIV_SEL2 and DIV_SEL3, in clock cycles per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, async; clears all state including fired |
| rst_n | input | 1 | System reset, active low, async; leaves fired intact |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_sel | input | 2 | Prescaler divisor select |
| hw_disable | input | 1 | Hardware unavailable; blocks all operation |
| rst_req | output | 1 | One-cycle system-reset request on expiry |
| shdn_req | output | 1 | One-cycle shutdown request on expiry |

## Verification
The assertions assume the following about the inputs:

- Bus accesses use only offsets 0x0 and 0x4.
- `tick_sel` changes only while the timer is stopped.
- `hw_disable` behaves as a slowly changing strap.
- No write arrives in the same cycle as an expiry.

The stimulus stays within these limits. Every write task drives a single-cycle access on the falling edge and then idles. The select is changed only before arming. The disable input is toggled only between scenarios, or while a countdown is far from its end. The expected expiry edges follow from the N·D rule and from the prescaler restarting on every reload and every start of the run bit.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned CNT_W     = 16;
  localparam int unsigned OFF_CTRL  = 0;
  localparam int unsigned OFF_COUNT = 4;
  localparam int unsigned B_RUN     = 0;
  localparam int unsigned B_FIRED   = 1;
  localparam int unsigned B_ACT     = 2;
  localparam int unsigned B_DIS     = 3;
  localparam int unsigned B_RELOAD  = 7;

  typedef enum logic {
    ACT_RESET    = 1'b0,
    ACT_SHUTDOWN = 1'b1
  } wdt_action_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV_SEL0 = 1,
  parameter int unsigned DIV_SEL1 = 1000,
  parameter int unsigned DIV_SEL2 = 1000000,
  parameter int unsigned DIV_SEL3 = 125000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int unsigned MAX01 = (DIV_SEL0 > DIV_SEL1) ? DIV_SEL0 : DIV_SEL1;
  localparam int unsigned MAX23 = (DIV_SEL2 > DIV_SEL3) ? DIV_SEL2 : DIV_SEL3;
  localparam int unsigned MAXD  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned CW    = (MAXD > 1) ? $clog2(MAXD) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  always_comb begin
    case (sel)
      2'd0:    limit = CW'(DIV_SEL0 - 1);
      2'd1:    limit = CW'(DIV_SEL1 - 1);
      2'd2:    limit = CW'(DIV_SEL2 - 1);
      default: limit = CW'(DIV_SEL3 - 1);
    endcase
  end

  assign tick = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              hw_disable,
  input  logic              expire,
  output logic              run_q,
  output wdt_action_e       action_q,
  output logic              reload_go,
  output logic              reload_q,
  output logic              fired_q,
  output logic [CNT_W-1:0]  prog_cnt
);
  logic wr_ctrl;
  logic wr_cnt;

  assign wr_ctrl   = bus_en & bus_we & (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_cnt    = bus_en & bus_we & (bus_addr == ADDR_W'(OFF_COUNT));
  assign reload_go = wr_ctrl & bus_wdata[B_RELOAD] & ~hw_disable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      action_q <= ACT_RESET;
      reload_q <= 1'b0;
      prog_cnt <= '0;
    end else begin
      reload_q <= reload_go;
      if (hw_disable || expire) run_q <= 1'b0;
      else if (wr_ctrl)         run_q <= bus_wdata[B_RUN];
      if (wr_ctrl) action_q <= wdt_action_e'(bus_wdata[B_ACT]);
      if (wr_cnt)  prog_cnt <= bus_wdata[CNT_W-1:0];
    end
  end

  // fired lives on the power-on reset only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                            fired_q <= 1'b0;
    else if (expire)                       fired_q <= 1'b1;
    else if (wr_ctrl && bus_wdata[B_FIRED]) fired_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CTRL)) begin
      bus_rdata[B_RUN]    = run_q;
      bus_rdata[B_FIRED]  = fired_q;
      bus_rdata[B_ACT]    = action_q;
      bus_rdata[B_DIS]    = hw_disable;
      bus_rdata[B_RELOAD] = reload_q;
    end else if (bus_addr == ADDR_W'(OFF_COUNT)) begin
      bus_rdata[CNT_W-1:0] = prog_cnt;
    end
  end
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             hw_disable,
  input  logic             reload_go,
  input  logic [CNT_W-1:0] prog_cnt,
  input  wdt_action_e      action,
  output logic             expire,
  output logic [CNT_W-1:0] live_cnt,
  output logic             rst_req,
  output logic             shdn_req
);
  logic [CNT_W-1:0] load_val;
  logic             step;

  assign load_val = (prog_cnt == '0) ? CNT_W'(1) : prog_cnt;
  assign step     = run & tick & ~hw_disable & ~reload_go;
  assign expire   = step & (live_cnt <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_cnt <= '0;
      rst_req  <= 1'b0;
      shdn_req <= 1'b0;
    end else begin
      if (reload_go)   live_cnt <= load_val;
      else if (expire) live_cnt <= '0;
      else if (step)   live_cnt <= live_cnt - 1'b1;
      rst_req  <= expire & (action == ACT_RESET);
      shdn_req <= expire & (action == ACT_SHUTDOWN);
    end
  end
endmodule

// File: rtl/wdt_periph.sv
module wdt_periph
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DIV_SEL0 = 1,
  parameter int unsigned DIV_SEL1 = 1000,
  parameter int unsigned DIV_SEL2 = 1000000,
  parameter int unsigned DIV_SEL3 = 125000000
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [1:0]        tick_sel,
  input  logic              hw_disable,
  output logic              rst_req,
  output logic              shdn_req
);
  logic             sys_rst_n;
  logic             run_w, reload_go_w, reload_w, fired_w, expire_w, tick_w;
  wdt_action_e      action_w;
  logic [CNT_W-1:0] prog_w, live_w;

  assign sys_rst_n = rst_n & por_n;

  wdt_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(sys_rst_n), .por_n(por_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_disable(hw_disable), .expire(expire_w),
    .run_q(run_w), .action_q(action_w), .reload_go(reload_go_w),
    .reload_q(reload_w), .fired_q(fired_w), .prog_cnt(prog_w)
  );

  wdt_prescaler #(
    .DIV_SEL0(DIV_SEL0), .DIV_SEL1(DIV_SEL1),
    .DIV_SEL2(DIV_SEL2), .DIV_SEL3(DIV_SEL3)
  ) pre_i (
    .clk(clk), .rst_n(sys_rst_n), .clr(reload_go_w | ~run_w),
    .sel(tick_sel), .tick(tick_w)
  );

  wdt_downcount cnt_i (
    .clk(clk), .rst_n(sys_rst_n), .run(run_w), .tick(tick_w),
    .hw_disable(hw_disable), .reload_go(reload_go_w), .prog_cnt(prog_w),
    .action(action_w), .expire(expire_w), .live_cnt(live_w),
    .rst_req(rst_req), .shdn_req(shdn_req)
  );
endmodule

// File: rtl/wdt_periph_chk.sv
module wdt_periph_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_n,
  input logic              hw_disable,
  input logic              rst_req,
  input logic              shdn_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              run_q,
  input logic              reload_q,
  input logic              fired_q,
  input logic [15:0]       live_cnt
);
  p_req_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !(rst_req && shdn_req));

  p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rst_req || shdn_req) |=> !(rst_req || shdn_req));

  p_expiry_state_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rst_req || shdn_req) |-> (fired_q && !run_q));

  p_disable_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    hw_disable |=> (!run_q && !reload_q && !rst_req && !shdn_req));

  p_reload_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    reload_q |-> (live_cnt != 16'd0));

  p_ctrl_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_addr == ADDR_W'(0)) |-> (bus_rdata[6:4] == 3'b000 && bus_rdata[31:8] == 24'd0));

  p_count_upper_r2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_addr == ADDR_W'(4)) |-> (bus_rdata[31:16] == 16'd0));
endmodule

bind wdt_periph wdt_periph_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .hw_disable(hw_disable),
  .rst_req(rst_req), .shdn_req(shdn_req), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .run_q(run_w), .reload_q(reload_w),
  .fired_q(fired_w), .live_cnt(live_w)
);

// File: tb/wdt_periph_tb_top.sv
module wdt_periph_tb_top;
  localparam int AW = 4;
  localparam int D0 = 2, D1 = 3, D2 = 4, D3 = 6;

  logic        clk = 1'b0;
  logic        por_n, rst_n, bus_en, bus_we, hw_disable, rst_req, shdn_req;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  tick_sel;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  wdt_periph #(.ADDR_W(AW), .DIV_SEL0(D0), .DIV_SEL1(D1), .DIV_SEL2(D2), .DIV_SEL3(D3)) dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_sel(tick_sel), .hw_disable(hw_disable), .rst_req(rst_req), .shdn_req(shdn_req)
  );

  always #4 clk = ~clk;

  function automatic int div_of(input logic [1:0] s);
    case (s)
      2'd0: return D0;
      2'd1: return D1;
      2'd2: return D2;
      default: return D3;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic arm(input int n, input logic [1:0] s, input bit act);
    tick_sel = s;
    wr(4, 32'(n));
    wr(0, {29'd0, act, 2'b11});
    wr(0, {24'd0, 1'b1, 4'd0, act, 2'b01});
  endtask

  // expects expiry exactly 'total' edges after return of the last write
  task automatic expect_fire(input int total, input bit act, input string req);
    bit early = 0;
    logic [31:0] v;
    for (int i = 1; i < total; i++) begin
      step(1);
      if (rst_req || shdn_req) early = 1;
    end
    chk(!early, {req, " no early request"}, 32'(early), 0);
    step(1);
    chk(rst_req == !act && shdn_req == act, {req, " request pulse (R6)"},
        {30'd0, shdn_req, rst_req}, act ? 32'd2 : 32'd1);
    rd(0, v);
    chk(v[1] == 1'b1 && v[0] == 1'b0, {req, " fired set, run cleared (R5)"}, v & 32'h3, 32'h2);
    step(1);
    chk(!rst_req && !shdn_req, {req, " pulse is one cycle (R6)"}, {30'd0, shdn_req, rst_req}, 0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); chk(v == 0, "R1 ctrl after reset", v, 0);
    rd(4, v); chk(v == 0, "R1 count after reset", v, 0);
    chk(!rst_req && !shdn_req, "R1 requests low", {30'd0, shdn_req, rst_req}, 0);
  endtask

  task automatic t_count_reg;
    logic [31:0] v;
    wr(4, 32'hABCD_1234);
    rd(4, v); chk(v == 32'h0000_1234, "R2 count readback", v, 32'h1234);
  endtask

  task automatic t_reserved;
    logic [31:0] v;
    wr(0, 32'hFFFF_FF70);
    rd(0, v); chk(v == 0, "R3 reserved bits ignored", v, 0);
  endtask

  task automatic t_reload_strobe;
    logic [31:0] v;
    wr(4, 5);
    wr(0, 32'h80);
    rd(0, v); chk(v[7] == 1'b1, "R4 reload bit set after write", v, 32'h80);
    step(1);
    rd(0, v); chk(v[7] == 1'b0, "R4 reload bit self-clears", v, 0);
    step(20);
    chk(!rst_req && !shdn_req, "R4 no expiry while stopped", {30'd0, shdn_req, rst_req}, 0);
  endtask

  task automatic t_expire_reset;
    arm(3, 2'd0, 1'b0);
    expect_fire(3 * div_of(0), 1'b0, "R5 reset action");
  endtask

  task automatic t_expire_shutdown;
    arm(2, 2'd1, 1'b1);
    expect_fire(2 * div_of(1), 1'b1, "R6 shutdown action R13 sel1");
  endtask

  task automatic t_sel3;
    arm(2, 2'd3, 1'b0);
    expect_fire(2 * div_of(3), 1'b0, "R13 sel3 period");
  endtask

  task automatic t_zero_count;
    arm(0, 2'd2, 1'b0);
    expect_fire(div_of(2), 1'b0, "R9 zero count");
  endtask

  task automatic t_kick;
    arm(4, 2'd0, 1'b0);
    step(5);
    wr(0, 32'h81);
    expect_fire(4 * div_of(0), 1'b0, "R8 kick restarts");
  endtask

  task automatic t_pause;
    logic [31:0] v;
    bit hit = 0;
    arm(4, 2'd0, 1'b0);
    step(2);
    wr(0, 32'h00);
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (rst_req || shdn_req) hit = 1;
    end
    chk(!hit, "R7 no expiry while paused", 32'(hit), 0);
    rd(0, v); chk(v[0] == 1'b0, "R7 run reads 0 while paused", v, 0);
    rd(4, v); chk(v == 4, "R7 programmed count kept", v, 4);
    wr(0, 32'h01);
    expect_fire(3 * div_of(0), 1'b0, "R7 resume with remaining ticks");
  endtask

  task automatic t_fired_w1c;
    logic [31:0] v;
    wr(0, 32'h00);
    rd(0, v); chk(v[1] == 1'b1, "R10 write 0 keeps fired", v, 32'h2);
    wr(0, 32'h02);
    rd(0, v); chk(v[1] == 1'b0, "R10 write 1 clears fired", v, 0);
  endtask

  task automatic t_sys_reset;
    logic [31:0] v;
    arm(1, 2'd0, 1'b0);
    expect_fire(div_of(0), 1'b0, "R11 setup expiry");
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
    rd(0, v); chk(v == 32'h2, "R11 fired survives system reset", v, 32'h2);
    rd(4, v); chk(v == 0, "R11 count cleared by system reset", v, 0);
    por_n = 1'b0; step(2); por_n = 1'b1; step(1);
    rd(0, v); chk(v == 0, "R11 power-on reset clears fired", v, 0);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    bit hit = 0;
    hw_disable = 1'b1; step(1);
    rd(0, v); chk(v[3] == 1'b1, "R12 disable status reads 1", v, 32'h8);
    tick_sel = 2'd0;
    wr(4, 1);
    wr(0, 32'h81);
    rd(0, v); chk(v[0] == 1'b0 && v[7] == 1'b0, "R12 run and reload blocked", v & 32'h81, 0);
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (rst_req || shdn_req) hit = 1;
    end
    chk(!hit, "R12 no request while disabled", 32'(hit), 0);
    hw_disable = 1'b0;
    arm(3, 2'd0, 1'b0);
    step(1);
    hw_disable = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (rst_req || shdn_req) hit = 1;
    end
    chk(!hit, "R12 running timer stopped by disable", 32'(hit), 0);
    rd(0, v); chk(v[0] == 1'b0, "R12 run cleared by disable", v, 0);
    hw_disable = 1'b0; step(1);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; tick_sel = 2'd0; hw_disable = 1'b0;
    step(3);
    por_n = 1'b1; rst_n = 1'b1;
    step(1);
    t_reset();
    t_count_reg();
    t_reserved();
    t_reload_strobe();
    t_expire_reset();
    t_expire_shutdown();
    t_sel3();
    t_zero_count();
    t_kick();
    t_pause();
    t_fired_w1c();
    t_sys_reset();
    t_disable();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule